// File: doc/BRIEF.md
# Dual-Port Burst-of-Two SRAM Core

This block is a synthesizable model of a quad-data-rate style memory. It has a read port and a write port that work independently. Each port can accept one request per input clock cycle, so both can run at full rate at once. Every access moves a burst of two words. The block keeps the two words together as a single double-width entry, split into byte lanes, and their order is fixed: the first word is always returned first. A burst cannot be addressed one word at a time, and its order cannot be reversed.

The model runs on one clock with one rising edge per half input cycle. An input phase flag, `k_ph`, tells the block which of the two edges is current. It is high on the primary (K) edge and low on the complementary (K#) edge. Reads and the first half of a write are taken on K edges. The second half of a write is taken on the K# edge that follows. Read data comes out after a fixed latency that is set by a parameter, counted in half cycles. The output has a drive enable that is high only while valid read data is present. An echo clock runs at all times. It follows the output clock phase, or the K phase when the output clock pair is parked high.

Top module: `burst2_sram`

## Requirements
- R1: On an edge with `k_ph`=1 and `rd_n`=0, the block captures a read and takes `addr` on that same edge. With LAT_HALF=3, the first word of the entry is on `q` with `q_oe`=1 after the 3rd following edge, and the second word is there after the 4th.
- R2: `rd_n` is ignored on edges with `k_ph`=0, and no output burst follows.
- R3: A write starts on an edge with `k_ph`=1 and `wr_n`=0, which captures word 0 from `d` and its enables from `bw_n`. The next edge (`k_ph`=0) captures `addr`, word 1 and its enables, and commits both words. `wr_n` is ignored on `k_ph`=0 edges.
- R4: A read returns the stored entry in write order: word 0 first, then word 1.
- R5: Byte enables are active low. Bit `bw_n[i]` guards data bits [9i+8:9i] of the word being captured. A byte whose enable is 1 keeps its previous stored value.
- R6: If both enables of one word are 1, that whole word of the burst is left unchanged, and the other word is still written.
- R7: If a read and a write to the same address start on the same K edge, the read returns the data stored before that write. A write started on an earlier K edge is visible.
- R8: `q_oe` is 0 on every edge where no read word is scheduled.
- R9: Reads on consecutive K edges give a continuous stream on `q`, with no gap between bursts.
- R10: When `oclk_park`=0, after each edge `cq` equals the `oclk_ph` value sampled on that edge, and `cq_n` is its inverse.
- R11: When `oclk_park`=1 (output clock pair held high), after each edge `cq` equals the `k_ph` value sampled on that edge.
- R12: During reset `q_oe` is 0. A write whose second half has not been taken when reset asserts is dropped, and memory is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock; each rising edge is a K or K# edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_ph | input | 1 | 1 on K edges, 0 on K# edges; alternates every edge |
| rd_n | input | 1 | Read select, active low, sampled on K edges |
| wr_n | input | 1 | Write select, active low, sampled on K edges |
| addr | input | AW | Read address on K edges, write address on K# edges |
| d | input | DW | Write data word |
| bw_n | input | DW/BW | Active-low byte enables for the current word |
| oclk_ph | input | 1 | Output clock phase: 1 on C edges, 0 on C# edges |
| oclk_park | input | 1 | 1 when the output clock pair is held high |
| q | output | DW | Read data word |
| q_oe | output | 1 | Output drive enable; 0 means high impedance |
| cq | output | 1 | Echo clock |
| cq_n | output | 1 | Complementary echo clock |

## Verification
The properties assume that `k_ph` flips on every clock edge, including across reset. The write-staging and echo properties rely on that alternation. The memory array has no reset, so stored data is defined only where it has been written. The bench therefore drives every edge through a single step routine that inverts the phase each time, and it writes all 64 entries before any read. Random traffic then mixes reads, writes, select pulses on K# edges, sparse byte masks and same-address collisions on a small address range. The output clock is either parked or driven in a chosen polarity.

// File: rtl/burst2_pkg.sv
package burst2_pkg;

   typedef enum logic {
      EDGE_KN = 1'b0,
      EDGE_K  = 1'b1
   } k_edge_e;

   // lane number of byte b of burst word w, with nb bytes per word
   function automatic int lane_of(input int w, input int b, input int nb);
      return w * nb + b;
   endfunction

endpackage

// File: rtl/b2_lane_array.sv
module b2_lane_array #(
   parameter int AW    = 6,
   parameter int BW    = 9,
   parameter int LANES = 4
) (
   input  logic                clk,
   input  logic [LANES-1:0]    we,
   input  logic [AW-1:0]       waddr,
   input  logic [LANES*BW-1:0] wdata,
   input  logic [AW-1:0]       raddr,
   output logic [LANES*BW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [BW-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (we[l]) store[waddr] <= wdata[l*BW +: BW];
      end

      assign rdata[l*BW +: BW] = store[raddr];
   end

endmodule

// File: rtl/b2_cmd_stage.sv
module b2_cmd_stage
   import burst2_pkg::*;
#(
   parameter int DW = 18,
   parameter int NB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          k_ph,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic [DW-1:0] d,
   input  logic [NB-1:0] bw_n,
   output logic          rd_fire,
   output logic          wr_commit,
   output logic          wpend,
   output logic [DW-1:0] w0_data,
   output logic [NB-1:0] w0_bwn
);
   k_edge_e cur_edge;
   assign cur_edge = k_edge_e'(k_ph);

   assign rd_fire   = (cur_edge == EDGE_K) && !rd_n;
   assign wr_commit = (cur_edge == EDGE_KN) && wpend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wpend   <= 1'b0;
         w0_data <= '0;
         w0_bwn  <= '1;
      end else if (cur_edge == EDGE_K) begin
         wpend <= !wr_n;
         if (!wr_n) begin
            w0_data <= d;
            w0_bwn  <= bw_n;
         end
      end else begin
         wpend <= 1'b0;
      end
   end

endmodule

// File: rtl/b2_read_seq.sv
module b2_read_seq #(
   parameter int DW  = 18,
   parameter int LAT = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_fire,
   input  logic [2*DW-1:0] rd_entry,
   output logic            out_v,
   output logic [DW-1:0]   out_word
);
   logic [LAT-1:0]  sv;
   logic [2*DW-1:0] sd [LAT];
   logic            hold_v;
   logic [DW-1:0]   hold_w;
   logic            tail_v;
   logic [2*DW-1:0] tail_d;

   assign tail_v = sv[LAT-1];
   assign tail_d = sd[LAT-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sv <= '0;
         for (int i = 0; i < LAT; i++) sd[i] <= '0;
      end else begin
         sv[0] <= rd_fire;
         if (rd_fire) sd[0] <= rd_entry;
         for (int i = 1; i < LAT; i++) begin
            sv[i] <= sv[i-1];
            sd[i] <= sd[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_v    <= 1'b0;
         out_word <= '0;
         hold_v   <= 1'b0;
         hold_w   <= '0;
      end else if (tail_v) begin
         out_v    <= 1'b1;
         out_word <= tail_d[DW-1:0];
         hold_v   <= 1'b1;
         hold_w   <= tail_d[2*DW-1:DW];
      end else if (hold_v) begin
         out_v    <= 1'b1;
         out_word <= hold_w;
         hold_v   <= 1'b0;
      end else begin
         out_v    <= 1'b0;
      end
   end

endmodule

// File: rtl/b2_echo.sv
module b2_echo (
   input  logic clk,
   input  logic rst_n,
   input  logic k_ph,
   input  logic oclk_ph,
   input  logic oclk_park,
   output logic cq,
   output logic cq_n
);
   logic src_ph;
   assign src_ph = oclk_park ? k_ph : oclk_ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cq <= 1'b0;
      else        cq <= src_ph;
   end

   assign cq_n = ~cq;

endmodule

// File: rtl/burst2_sram.sv
module burst2_sram
   import burst2_pkg::*;
#(
   parameter int AW       = 6,
   parameter int DW       = 18,
   parameter int BW       = 9,
   parameter int LAT_HALF = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             k_ph,
   input  logic             rd_n,
   input  logic             wr_n,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    d,
   input  logic [DW/BW-1:0] bw_n,
   input  logic             oclk_ph,
   input  logic             oclk_park,
   output logic [DW-1:0]    q,
   output logic             q_oe,
   output logic             cq,
   output logic             cq_n
);
   localparam int NB    = DW / BW;
   localparam int LANES = 2 * NB;
   localparam int EW    = LANES * BW;

   if (DW % BW != 0) begin : g_bad_lane
      $error("burst2_sram: DW must be a whole number of BW-bit bytes");
   end
   if (LAT_HALF < 1) begin : g_bad_lat
      $error("burst2_sram: LAT_HALF must be at least 1");
   end
   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("burst2_sram: AW out of range");
   end

   logic             rd_fire;
   logic             wr_commit;
   logic             wpend;
   logic [DW-1:0]    w0_data;
   logic [NB-1:0]    w0_bwn;
   logic [LANES-1:0] lane_we;
   logic [EW-1:0]    lane_wd;
   logic [EW-1:0]    lane_rd;
   logic             out_v;
   logic [DW-1:0]    out_word;

   b2_cmd_stage #(.DW(DW), .NB(NB)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .k_ph      (k_ph),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .d         (d),
      .bw_n      (bw_n),
      .rd_fire   (rd_fire),
      .wr_commit (wr_commit),
      .wpend     (wpend),
      .w0_data   (w0_data),
      .w0_bwn    (w0_bwn)
   );

   for (genvar w = 0; w < 2; w++) begin : g_word
      for (genvar b = 0; b < NB; b++) begin : g_byte
         localparam int LI = lane_of(w, b, NB);
         if (w == 0) begin : g_first
            assign lane_we[LI]            = wr_commit && !w0_bwn[b];
            assign lane_wd[LI*BW +: BW]   = w0_data[b*BW +: BW];
         end else begin : g_second
            assign lane_we[LI]            = wr_commit && !bw_n[b];
            assign lane_wd[LI*BW +: BW]   = d[b*BW +: BW];
         end
      end
   end

   b2_lane_array #(.AW(AW), .BW(BW), .LANES(LANES)) u_arr (
      .clk   (clk),
      .we    (lane_we),
      .waddr (addr),
      .wdata (lane_wd),
      .raddr (addr),
      .rdata (lane_rd)
   );

   b2_read_seq #(.DW(DW), .LAT(LAT_HALF)) u_rseq (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_fire  (rd_fire),
      .rd_entry (lane_rd),
      .out_v    (out_v),
      .out_word (out_word)
   );

   assign q    = out_word;
   assign q_oe = out_v;

   b2_echo u_echo (
      .clk       (clk),
      .rst_n     (rst_n),
      .k_ph      (k_ph),
      .oclk_ph   (oclk_ph),
      .oclk_park (oclk_park),
      .cq        (cq),
      .cq_n      (cq_n)
   );

endmodule

// File: rtl/burst2_sram_chk.sv
module burst2_sram_chk (
   input logic clk,
   input logic rst_n,
   input logic k_ph,
   input logic oclk_ph,
   input logic oclk_park,
   input logic cq,
   input logic q_oe,
   input logic wpend
);
   // input rule: the phase flag alternates on every edge
   phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      k_ph != $past(k_ph));

   // R3
   stage_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wpend |-> !k_ph);

   // R9
   burst_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q_oe) |=> q_oe);

   // R10
   echo_oclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oclk_park |=> (cq == $past(oclk_ph)));

   // R11
   echo_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oclk_park |=> (cq == $past(k_ph)));

endmodule

bind burst2_sram burst2_sram_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .k_ph      (k_ph),
   .oclk_ph   (oclk_ph),
   .oclk_park (oclk_park),
   .cq        (cq),
   .q_oe      (q_oe),
   .wpend     (wpend)
);

// File: tb/burst2_sram_bench.sv
module burst2_sram_bench;
   localparam int CLK_P = 10;
   localparam int AW = 6, DW = 18, BW = 9, NB = 2, LAT = 3;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic k_ph = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] d = '0;
   logic [NB-1:0] bw_n = '1;
   logic oclk_ph = 1'b0, oclk_park = 1'b0;
   logic [DW-1:0] q;
   logic q_oe, cq, cq_n;

   always #(CLK_P/2) clk = ~clk;

   burst2_sram #(.AW(AW), .DW(DW), .BW(BW), .LAT_HALF(LAT)) u_burst2_sram (
      .clk(clk), .rst_n(rst_n), .k_ph(k_ph), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .d(d), .bw_n(bw_n), .oclk_ph(oclk_ph),
      .oclk_park(oclk_park), .q(q), .q_oe(q_oe), .cq(cq), .cq_n(cq_n)
   );

   int checks = 0, errors = 0;
   logic [2*DW-1:0] mmem [DEPTH];
   logic            ring_v [8];
   logic [DW-1:0]   ring_d [8];
   string           ring_t [8];
   logic            pend = 1'b0;
   logic [DW-1:0]   pw0;
   logic [NB-1:0]   pbw0;
   logic            kph_next = 1'b1;
   logic            opolar = 1'b1;
   string           idle_tag = "R8";
   int              e = 0;

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                           input logic [DW-1:0] nw,
                                           input logic [NB-1:0] bwn);
      logic [DW-1:0] r = old;
      for (int b = 0; b < NB; b++)
         if (!bwn[b]) r[b*BW +: BW] = nw[b*BW +: BW];
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (edge %0d)", tag, act, exp, e);
      end
   endtask

   task automatic model_edge(input string tag);
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) ring_v[i] = 1'b0;
         pend = 1'b0;
         return;
      end
      if (k_ph && !rd_n) begin
         ring_v[(e+LAT)%8] = 1'b1;   ring_d[(e+LAT)%8] = mmem[addr][DW-1:0];
         ring_t[(e+LAT)%8] = tag;
         ring_v[(e+LAT+1)%8] = 1'b1; ring_d[(e+LAT+1)%8] = mmem[addr][2*DW-1:DW];
         ring_t[(e+LAT+1)%8] = tag;
      end
      if (!k_ph && pend) begin
         mmem[addr] = {merge(mmem[addr][2*DW-1:DW], d, bw_n),
                       merge(mmem[addr][DW-1:0], pw0, pbw0)};
         pend = 1'b0;
      end
      if (k_ph && !wr_n) begin
         pend = 1'b1; pw0 = d; pbw0 = bw_n;
      end
   endtask

   task automatic check_edge(input logic exp_cq);
      int s = e % 8;
      if (!rst_n) begin
         chk(q_oe == 1'b0, "R12 q_oe in reset", {17'b0, q_oe}, '0);
      end else begin
         chk(q_oe == ring_v[s], ring_v[s] ? ring_t[s] : idle_tag, {17'b0, q_oe},
             {17'b0, ring_v[s]});
         if (ring_v[s] && q_oe) chk(q == ring_d[s], ring_t[s], q, ring_d[s]);
         chk(cq == exp_cq && cq_n == !exp_cq, oclk_park ? "R11 echo" : "R10 echo",
             {16'b0, cq, cq_n}, {16'b0, exp_cq, !exp_cq});
      end
      ring_v[s] = 1'b0;
   endtask

   task automatic step(input logic rdn, input logic wrn, input logic [AW-1:0] a,
                       input logic [DW-1:0] dd, input logic [NB-1:0] bw, input string tag);
      logic exp_cq;
      k_ph = kph_next; rd_n = rdn; wr_n = wrn; addr = a; d = dd; bw_n = bw;
      oclk_ph = opolar ? kph_next : !kph_next;
      exp_cq = oclk_park ? k_ph : oclk_ph;
      @(posedge clk);
      model_edge(tag);
      @(negedge clk);
      check_edge(exp_cq);
      e++;
      kph_next = !kph_next;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b1, 1'b1, '0, '0, '1, "R8");
   endtask

   // one K/K# pair; rdn2/wrn2 are selects driven on the K# edge
   task automatic kcycle(input logic rdn, input logic [AW-1:0] ra, input logic wrn,
                         input logic [AW-1:0] wa, input logic [DW-1:0] w0,
                         input logic [DW-1:0] w1, input logic [NB-1:0] b0,
                         input logic [NB-1:0] b1, input logic rdn2, input logic wrn2,
                         input string tag);
      if (!kph_next) idle(1);
      step(rdn, wrn, ra, w0, b0, tag);
      step(rdn2, wrn2, wa, w1, b1, tag);
   endtask

   initial begin : watchdog
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int unsigned seed = 32'h5eed_1234;
      for (int i = 0; i < 8; i++) ring_v[i] = 1'b0;
      void'($urandom(seed));
      @(negedge clk);
      idle(4);                              // R12 reset state
      rst_n = 1'b1;
      idle(2);

      for (int a = 0; a < DEPTH; a++)       // fill: R3 R4
         kcycle(1'b1, '0, 1'b0, a[AW-1:0], DW'(a * 3 + 1), DW'(a * 7 + 2),
                '0, '0, 1'b1, 1'b1, "R3");
      kcycle(1'b0, 6'd5, 1'b1, '0, '0, '0, '1, '1, 1'b1, 1'b1, "R1 R4 read");
      idle(6);

      kcycle(1'b1, '0, 1'b0, 6'd7, 18'h3ffff, 18'h2aaaa, 2'b01, 2'b10,
             1'b1, 1'b1, "R5");
      kcycle(1'b0, 6'd7, 1'b1, '0, '0, '0, '1, '1, 1'b1, 1'b1, "R5 mask");
      idle(6);

      kcycle(1'b1, '0, 1'b0, 6'd8, 18'h11111, 18'h22222, 2'b11, 2'b00,
             1'b1, 1'b1, "R6");
      kcycle(1'b0, 6'd8, 1'b1, '0, '0, '0, '1, '1, 1'b1, 1'b1, "R6 skip");
      idle(6);

      kcycle(1'b0, 6'd9, 1'b0, 6'd9, 18'h0abcd, 18'h1dcba, '0, '0,
             1'b1, 1'b1, "R7 old");
      kcycle(1'b0, 6'd9, 1'b1, '0, '0, '0, '1, '1, 1'b1, 1'b1, "R7 new");
      idle(6);

      idle_tag = "R2";
      kcycle(1'b1, '0, 1'b1, 6'd3, '0, '0, '1, '1, 1'b0, 1'b1, "R2");
      idle(6);
      idle_tag = "R8";

      kcycle(1'b1, '0, 1'b1, 6'd10, 18'h3ffff, 18'h3ffff, '0, '0, 1'b1, 1'b0, "R3 ign");
      idle(2);
      kcycle(1'b0, 6'd10, 1'b1, '0, '0, '0, '1, '1, 1'b1, 1'b1, "R3 ign check");
      idle(6);

      for (int i = 0; i < 4; i++)
         kcycle(1'b0, 6'(11 + i), 1'b1, '0, '0, '0, '1, '1, 1'b1, 1'b1, "R9");
      idle(6);

      oclk_park = 1'b1;
      idle(6);
      oclk_park = 1'b0; opolar = 1'b0;
      idle(6);

      kcycle(1'b1, '0, 1'b0, 6'd20, 18'h15555, 18'h0f0f0, '0, '0, 1'b1, 1'b1, "R12");
      if (!kph_next) idle(1);
      step(1'b1, 1'b0, '0, 18'h3ffff, '0, "R12");
      rst_n = 1'b0;
      idle(4);
      rst_n = 1'b1;
      idle(2);
      kcycle(1'b0, 6'd20, 1'b1, '0, '0, '0, '1, '1, 1'b1, 1'b1, "R12 dropped");
      idle(6);

      for (int i = 0; i < 1500; i++) begin
         logic [NB-1:0] b0, b1;
         if (i % 100 == 0) begin
            oclk_park = 1'($urandom % 2);
            opolar = 1'($urandom % 2);
         end
         b0 = ($urandom % 4 == 0) ? 2'b11 : 2'($urandom);
         b1 = ($urandom % 4 == 0) ? 2'b11 : 2'($urandom);
         kcycle(1'($urandom % 2), 6'($urandom % 8), 1'($urandom % 2),
                6'($urandom % 8), 18'($urandom), 18'($urandom), b0, b1,
                1'($urandom % 2), 1'($urandom % 2), "R1 R4 R5 R7 rand");
      end
      idle(8);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule